// File: doc/BRIEF.md
# QoS-Acceptance Filtered Request Arbiter

This block sits on the interconnect side of a link to a single downstream target, such as a memory controller. Several upstream requesters each offer one request with a 4-bit QoS value, a read/write flag and a payload. The target publishes two acceptance thresholds, one for reads and one for writes. Each threshold is the QoS level the target is currently willing to take.

The arbiter forwards only requests that clear the threshold for their own channel. A low-priority request is held back upstream. It is never put on the downstream port, where it would stall the link.

The thresholds are quasi-static and are not tied to the request handshake. Each one passes through a two-flop synchroniser before use. The arbiter samples them only when it is free to make a new choice.

Among eligible requests, the highest QoS wins. Ties are broken by a round-robin pointer.

Once a request is presented, it is held until the target accepts it, whatever the thresholds do in the meantime.

Top module: `qos_accept_arb`

## Requirements
- R1: Each threshold input reaches the selection logic through exactly two clock-domain flops. A threshold change applied before clock edge 1 can first alter `dn_valid` or `dn_src` at edge 3.
- R2: A request is eligible when its QoS is strictly greater than the synchronised threshold of its channel. `up_write[i]`=1 selects the write threshold and 0 selects the read threshold. A threshold of 0 makes every request of that channel eligible, including QoS 0.
- R3: An ineligible request is never presented. When no valid request is eligible at a choice point, `dn_valid` is low after the next edge.
- R4: Among eligible requests, the one with the highest QoS is granted.
- R5: Among eligible requests that share the highest QoS, the grant goes to the first index at or above the round-robin pointer, wrapping past N_REQ-1 to 0. After each accepted handshake the pointer moves to the granted index plus one, wrapping. The pointer is 0 after reset and changes at no other time.
- R6: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_src` and the presented fields stay unchanged. This holds even if a threshold rises above the presented QoS.
- R7: `up_ready[i]` is high only when `dn_valid` and `dn_ready` are both high and `dn_src` equals i. At most one bit is set. In the handshake cycle the accepted requester is excluded from the next choice, so the following grant can go to another pending request on the next edge.
- R8: While reset is asserted and after it is released, `dn_valid` is 0 and `up_ready` is all zeros until a request is granted.
- R9: `dn_src` is the granted index. `dn_write`, `dn_qos` and `dn_data` equal that requester's `up_write`, `up_qos` and `up_data` fields. QoS of requester i sits at bits [4i+3:4i] and payload at bits [PW*i+PW-1:PW*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | N_REQ | Request pending, one bit per requester |
| up_write | input | N_REQ | 1 = write request, 0 = read request |
| up_qos | input | 4*N_REQ | Packed QoS values, 4 bits per requester |
| up_data | input | PW*N_REQ | Packed request payloads |
| up_ready | output | N_REQ | Request accepted, one bit per requester |
| rd_accept_thr | input | 4 | Read acceptance threshold from the target (asynchronous) |
| wr_accept_thr | input | 4 | Write acceptance threshold from the target (asynchronous) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream target accepts |
| dn_write | output | 1 | Presented request is a write |
| dn_qos | output | 4 | Presented QoS |
| dn_data | output | PW | Presented payload |
| dn_src | output | SRC_W | Index of the granted requester |

## Verification
The bench applies thresholds that are equal to some request QoS values. This exposes a design that compares with greater-or-equal, and one that reads the wrong channel's threshold for reads or writes. Repeated ties show whether the round-robin pointer wraps and advances past the winner; a stuck or off-by-one pointer grants the same index again.

A threshold is raised while a grant is waiting for ready. An arbiter that re-evaluates eligibility mid-grant would drop or swap the presented request.

A threshold step is timed edge by edge to catch a synchroniser with one flop too many or too few. A back-to-back case checks that the just-accepted requester is masked; without the mask, that requester would be granted twice.

// File: rtl/qaa_pkg.sv
package qaa_pkg;
  // QoS field width is fixed by the link definition.
  parameter int unsigned QAA_QOS_W = 4;

  typedef logic [QAA_QOS_W-1:0] qos_t;

  // Eligibility rule: strictly above the threshold, or threshold zero.
  function automatic logic qos_passes(qos_t q, qos_t thr);
    return (thr == '0) || (q > thr);
  endfunction
endpackage

// File: rtl/qaa_sync.sv
module qaa_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/qaa_pick.sv
module qaa_pick
  import qaa_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned SRC_W = 2
) (
  input  logic [N_REQ-1:0]           cand,
  input  logic [N_REQ-1:0]           is_write,
  input  logic [N_REQ*QAA_QOS_W-1:0] qos_flat,
  input  qos_t                       rd_thr,
  input  qos_t                       wr_thr,
  input  logic [SRC_W-1:0]           rr_ptr,
  output logic                       any_elig,
  output logic [SRC_W-1:0]           win_idx
);
  qos_t             qos_arr [N_REQ];
  logic [N_REQ-1:0] elig;
  qos_t             top_qos;
  logic             found;

  for (genvar g = 0; g < N_REQ; g++) begin : g_unpack
    assign qos_arr[g] = qos_flat[g*QAA_QOS_W +: QAA_QOS_W];
    assign elig[g]    = cand[g] &
                        qos_passes(qos_arr[g], is_write[g] ? wr_thr : rd_thr);
  end

  // Highest QoS among eligible requesters.
  always_comb begin
    top_qos = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (elig[i] && (qos_arr[i] > top_qos)) top_qos = qos_arr[i];
    end
  end

  // First eligible at top QoS, searching upward from the pointer with wrap.
  always_comb begin
    win_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      int j;
      j = int'(rr_ptr) + k;
      if (j >= int'(N_REQ)) j = j - int'(N_REQ);
      if (!found && elig[j] && (qos_arr[j] == top_qos)) begin
        win_idx = SRC_W'(j);
        found   = 1'b1;
      end
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/qos_accept_arb.sv
module qos_accept_arb
  import qaa_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned PW    = 16,
  parameter int unsigned SRC_W = $clog2(N_REQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REQ-1:0]           up_valid,
  input  logic [N_REQ-1:0]           up_write,
  input  logic [N_REQ*QAA_QOS_W-1:0] up_qos,
  input  logic [N_REQ*PW-1:0]        up_data,
  output logic [N_REQ-1:0]           up_ready,
  input  logic [QAA_QOS_W-1:0]       rd_accept_thr,
  input  logic [QAA_QOS_W-1:0]       wr_accept_thr,
  output logic                       dn_valid,
  input  logic                       dn_ready,
  output logic                       dn_write,
  output logic [QAA_QOS_W-1:0]       dn_qos,
  output logic [PW-1:0]              dn_data,
  output logic [SRC_W-1:0]           dn_src
);
  localparam logic [SRC_W-1:0] LAST_IDX = SRC_W'(N_REQ - 1);

  qos_t             rd_thr_s;
  qos_t             wr_thr_s;
  logic             vld_q,  vld_d;
  logic [SRC_W-1:0] gnt_q,  gnt_d;
  logic [SRC_W-1:0] rr_q,   rr_d;
  logic             hs;
  logic             load;
  logic [N_REQ-1:0] hs_mask;
  logic [N_REQ-1:0] cand;
  logic             pick_any;
  logic [SRC_W-1:0] pick_idx;

  qaa_sync #(.W(QAA_QOS_W)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rd_accept_thr), .sync_out(rd_thr_s));
  qaa_sync #(.W(QAA_QOS_W)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wr_accept_thr), .sync_out(wr_thr_s));

  qaa_pick #(.N_REQ(N_REQ), .SRC_W(SRC_W)) u_pick (
    .cand    (cand),
    .is_write(up_write),
    .qos_flat(up_qos),
    .rd_thr  (rd_thr_s),
    .wr_thr  (wr_thr_s),
    .rr_ptr  (rr_q),
    .any_elig(pick_any),
    .win_idx (pick_idx)
  );

  // Next-state logic.
  always_comb begin
    hs      = vld_q & dn_ready;
    load    = ~vld_q | dn_ready;
    hs_mask = '0;
    if (hs) hs_mask[gnt_q] = 1'b1;
    cand    = up_valid & ~hs_mask;

    vld_d = vld_q;
    gnt_d = gnt_q;
    if (load) begin
      vld_d = pick_any;
      if (pick_any) gnt_d = pick_idx;
    end

    rr_d = rr_q;
    if (hs) rr_d = (gnt_q == LAST_IDX) ? '0 : gnt_q + 1'b1;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      gnt_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) gnt_q <= gnt_d;
      if (hs)   rr_q  <= rr_d;
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_ready
    assign up_ready[g] = hs & (gnt_q == SRC_W'(g));
  end

  assign dn_valid = vld_q;
  assign dn_src   = gnt_q;
  assign dn_write = up_write[gnt_q];
  assign dn_qos   = up_qos[gnt_q*QAA_QOS_W +: QAA_QOS_W];
  assign dn_data  = up_data[gnt_q*PW +: PW];
endmodule

// File: rtl/qaa_checker.sv
module qaa_checker
  import qaa_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] up_ready,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic             dn_write,
  input qos_t             dn_qos,
  input logic [SRC_W-1:0] dn_src,
  input logic             load,
  input logic             pick_any,
  input qos_t             rd_thr_s,
  input qos_t             wr_thr_s
);
  // R2 / R3: a freshly loaded grant clears the threshold sampled at load.
  p_elig_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pick_any) |=> (dn_write ? ($past(wr_thr_s) == '0 || dn_qos > $past(wr_thr_s))
                                     : ($past(rd_thr_s) == '0 || dn_qos > $past(rd_thr_s))));

  // R3: nothing eligible at a choice point leaves the port idle.
  p_idle_when_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pick_any) |=> !dn_valid);

  // R6: a waiting grant holds.
  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_src)));

  // R7: ready is one-hot and only on a handshake of the granted index.
  p_ready_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_ready));
  p_ready_on_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|up_ready) |-> (dn_valid && dn_ready && up_ready[dn_src]));

  // R8: after reset release nothing is presented in the first cycle.
  p_reset_idle_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dn_valid && up_ready == '0));
endmodule

bind qos_accept_arb qaa_checker #(.N_REQ(N_REQ), .SRC_W(SRC_W)) u_qaa_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_ready(up_ready),
  .dn_valid(dn_valid),
  .dn_ready(dn_ready),
  .dn_write(dn_write),
  .dn_qos  (dn_qos),
  .dn_src  (dn_src),
  .load    (load),
  .pick_any(pick_any),
  .rd_thr_s(rd_thr_s),
  .wr_thr_s(wr_thr_s)
);

// File: tb/tb_qos_accept_arb.sv
module tb_qos_accept_arb;
  localparam int N  = 4;
  localparam int PW = 16;
  localparam int SW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  up_valid;
  logic [N-1:0]  up_write;
  logic [4*N-1:0] up_qos;
  logic [PW*N-1:0] up_data;
  logic [N-1:0]  up_ready;
  logic [3:0]    rd_thr;
  logic [3:0]    wr_thr;
  logic          dn_valid;
  logic          dn_ready;
  logic          dn_write;
  logic [3:0]    dn_qos;
  logic [PW-1:0] dn_data;
  logic [SW-1:0] dn_src;

  int total = 0;
  int bad   = 0;

  qos_accept_arb #(.N_REQ(N), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_write(up_write), .up_qos(up_qos), .up_data(up_data),
    .up_ready(up_ready),
    .rd_accept_thr(rd_thr), .wr_accept_thr(wr_thr),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_qos(dn_qos), .dn_data(dn_data), .dn_src(dn_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  vmask;
    logic [3:0]  wmask;
    logic [15:0] qos;
    logic [3:0]  rd;
    logic [3:0]  wr;
    logic        ev;
    logic [1:0]  es;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{4'b1111, 4'b0000, 16'h2773, 4'd0, 4'd0,  1'b1, 2'd1},  // R4 R5 tie from ptr 0
    '{4'b1111, 4'b0000, 16'h2773, 4'd0, 4'd0,  1'b1, 2'd2},  // R5 ptr 2
    '{4'b1111, 4'b0000, 16'h2773, 4'd0, 4'd0,  1'b1, 2'd1},  // R5 wrap from 3
    '{4'b1111, 4'b0101, 16'hC549, 4'd4, 4'd9,  1'b1, 2'd3},  // R2 equal is not enough
    '{4'b1111, 4'b1111, 16'hFFFF, 4'd0, 4'd15, 1'b0, 2'd0},  // R3 none eligible
    '{4'b0110, 4'b0000, 16'h0000, 4'd0, 4'd5,  1'b1, 2'd1},  // R2 zero threshold
    '{4'b1001, 4'b1000, 16'h6006, 4'd5, 4'd5,  1'b1, 2'd3},  // R2 R5 mixed channels
    '{4'b1111, 4'b0000, 16'h4321, 4'd3, 4'd0,  1'b1, 2'd3}   // R4 only top passes
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_fields(input int src, input string tag);
    chk(dn_src == SW'(src), {tag, " R9 src"}, int'(dn_src), src);
    chk(dn_qos == up_qos[src*4 +: 4], {tag, " R9 qos"}, int'(dn_qos), int'(up_qos[src*4 +: 4]));
    chk(dn_write == up_write[src], {tag, " R9 write"}, int'(dn_write), int'(up_write[src]));
    chk(dn_data == PW'(16'h00D0 + src), {tag, " R9 data"}, int'(dn_data), 16'h00D0 + src);
  endtask

  // Accept the presented request; other requesters withdraw at the same time.
  task automatic accept(input int src, input string tag);
    dn_ready = 1'b1;
    up_valid = '0;
    up_valid[src] = 1'b1;
    #1;
    chk(up_ready == (N'(1) << src), {tag, " R7 ready"}, int'(up_ready), 1 << src);
    tick(1);
    dn_ready = 1'b0;
    up_valid = '0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) up_data[i*PW +: PW] = PW'(16'h00D0 + i);
    up_valid = '0; up_write = '0; up_qos = '0;
    rd_thr = '0; wr_thr = '0; dn_ready = 1'b0;
    rst_n = 1'b0;
    tick(3);
    chk(dn_valid == 1'b0, "R8 valid in reset", int'(dn_valid), 0);
    chk(up_ready == '0, "R8 ready in reset", int'(up_ready), 0);
    rst_n = 1'b1;
    tick(2);
    chk(dn_valid == 1'b0, "R8 valid after reset", int'(dn_valid), 0);

    // Vector table walk.
    for (int v = 0; v < 8; v++) begin
      string tag;
      tag = $sformatf("vec%0d", v);
      rd_thr = TBL[v].rd;
      wr_thr = TBL[v].wr;
      tick(4);
      up_valid = TBL[v].vmask;
      up_write = TBL[v].wmask;
      up_qos   = TBL[v].qos;
      tick(1);
      chk(dn_valid == TBL[v].ev, {tag, " R2 R3 valid"}, int'(dn_valid), int'(TBL[v].ev));
      if (TBL[v].ev) begin
        chk(dn_src == TBL[v].es, {tag, " R4 R5 winner"}, int'(dn_src), int'(TBL[v].es));
        check_fields(int'(TBL[v].es), tag);
        accept(int'(TBL[v].es), tag);
      end else begin
        tick(1);
        chk(dn_valid == 1'b0, {tag, " R3 stays idle"}, int'(dn_valid), 0);
        up_valid = '0;
      end
      chk(dn_valid == 1'b0, {tag, " R7 drained"}, int'(dn_valid), 0);
    end

    // R1: synchroniser latency. Pointer is 0 here.
    rd_thr = 4'd15;
    tick(4);
    up_valid = 4'b0001; up_write = '0; up_qos = 16'h0005;
    tick(2);
    chk(dn_valid == 1'b0, "R1 blocked before change", int'(dn_valid), 0);
    rd_thr = 4'd0;
    tick(1);
    chk(dn_valid == 1'b0, "R1 edge1", int'(dn_valid), 0);
    tick(1);
    chk(dn_valid == 1'b0, "R1 edge2", int'(dn_valid), 0);
    tick(1);
    chk(dn_valid == 1'b1, "R1 edge3", int'(dn_valid), 1);
    accept(0, "R1");   // pointer -> 1

    // R6: hold while threshold rises above the presented QoS.
    up_valid = 4'b0001; up_qos = 16'h0003;
    tick(1);
    chk(dn_valid == 1'b1, "R6 granted", int'(dn_valid), 1);
    rd_thr = 4'd10;
    tick(5);
    chk(dn_valid == 1'b1, "R6 still valid", int'(dn_valid), 1);
    chk(dn_src == 2'd0, "R6 same src", int'(dn_src), 0);
    chk(dn_qos == 4'd3, "R6 same qos", int'(dn_qos), 3);
    accept(0, "R6");   // pointer -> 1
    up_valid = 4'b0001;
    tick(1);
    chk(dn_valid == 1'b0, "R3 blocked after raise", int'(dn_valid), 0);
    up_valid = '0;

    // R7 back-to-back: accepted requester masked, next goes to the other.
    rd_thr = 4'd0;
    tick(4);
    up_valid = 4'b0011; up_write = '0; up_qos = 16'h0088;
    tick(1);
    chk(dn_src == 2'd1, "R5 ptr1 tie", int'(dn_src), 1);
    dn_ready = 1'b1;
    #1;
    chk(up_ready == 4'b0010, "R7 ready b2b", int'(up_ready), 2);
    tick(1);
    chk(dn_valid == 1'b1, "R7 next valid", int'(dn_valid), 1);
    chk(dn_src == 2'd0, "R7 masked repick", int'(dn_src), 0);
    accept(0, "R7 second");
    chk(dn_valid == 1'b0, "R7 idle end", int'(dn_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule